// File: doc/BRIEF.md
# Instruction Cache Line-Fill Controller

A small direct-mapped instruction cache that sits between an instruction fetch unit and a longword memory port. Each fetch is answered from one of three places: a one-line fill buffer holding the line most recently brought in from memory, the tag/data array, or memory itself. A fetch that misses both the buffer and the array starts a line fill. The fill asks for the requested longword first and then walks the rest of the line, wrapping within the 16-byte line. The requested word goes to the CPU as soon as memory delivers it.

The fill buffer is not written into the array while it is being filled. A recency flag marks the buffer as the current copy of its line. When the next miss needs the buffer, a fully valid buffer is written into its direct-mapped set in a single cycle, and the new fill starts after that. Fetches that are cache-inhibited, marked as control-space, or issued while the cache is disabled go around both structures as a single memory transfer.

A 2-bit fill-mode field picks between whole-line fills and single-longword fills. Enable and fill mode are held in a control register that reset clears. Tag and valid storage keeps its contents through reset, so software must pulse invalidate-all before it enables the cache.

Top module: `icache_fill_ctrl`

## Requirements
- R1: While rst_ni is low, fetch_ready_o and mem_req_o are 0 even with fetch_req_i high. After reset the cache is disabled until cache_en_i has been sampled high.
- R2: cache_en_i and fill_mode_i are captured in a control register and take effect one clock after they change. While the registered enable is 0, every fetch becomes one memory transfer.
- R3: With the cache enabled, a fetch with inhibit_i=0 and ctrl_space_i=0 that hits neither the fill buffer nor the array starts a fill from memory. Each longword of the fill is written into the buffer exactly once.
- R4: A line fill first requests the longword at mem_addr_o = {addr[31:4], addr[3:2], 2'b00}. The next three requests add 4 to byte offset bits [3:2], wrapping modulo 16, so offset 0x4 gives 0x4, 0x8, 0xC, 0x0.
- R5: The requested word is returned with fetch_ready_o=1 and fetch_data_o=mem_data_i in the cycle its mem_ack_i is seen. After that, no fetch gets ready until the fill ends. mem_addr_o holds steady while mem_req_o waits for mem_ack_i.
- R6: A fetch that hits valid buffer words is answered in the same cycle it is presented, with no memory transfer.
- R7: A fetch with inhibit_i=1 or ctrl_space_i=1 makes exactly one memory transfer at {addr[31:2], 2'b00} and returns its data. It changes neither the buffer nor the array.
- R8: Fill mode 2'b00 always fills 4 longwords. Mode 2'b01 fills 4 when addr[3]=0 and 1 when addr[3]=1. Modes 2'b10 and 2'b11 fill 1. After a 1-longword fill, only that word of the buffer hits.
- R9: On a miss, a buffer that is fully valid and most-recently-used is first written into array set line[IDX_W-1:0] in one cycle. That line then hits in the array with no memory transfer.
- R10: An invalidate_all_i pulse clears every array valid bit and the buffer's valid and recency state. Afterwards every cacheable fetch misses.
- R11: Reset leaves the array tags, valid bits and data unchanged (the buffer is cleared). A line copied into the array before reset hits once the cache is re-enabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cache_en_i | input | 1 | Cache enable, registered |
| fill_mode_i | input | 2 | Line-fill mode, registered |
| inval_all_i | input | 1 | Invalidate-all pulse |
| fetch_req_i | input | 1 | Fetch request, held until fetch_ready_o |
| fetch_addr_i | input | 32 | Fetch byte address |
| inhibit_i | input | 1 | Fetch is cache-inhibited |
| ctrl_space_i | input | 1 | Fetch targets control space |
| fetch_ready_o | output | 1 | Fetch completes this cycle |
| fetch_data_o | output | 32 | Instruction word |
| mem_req_o | output | 1 | Memory longword request |
| mem_addr_o | output | 32 | Memory longword address |
| mem_ack_i | input | 1 | Memory acknowledge, data valid |
| mem_data_i | input | 32 | Memory read data |

## Verification
A wrong valid bit, tag, or recency flag shows at the ports as a miss or a hit that should not happen. The memory transfer count for that fetch then differs from the expected one, and this can be seen within a few cycles of the fetch completing. A stale buffer word or array word appears as a wrong fetch_data_o in the very cycle fetch_ready_o is high. A wrong fill counter or wrap shows up as a mem_addr_o sequence that breaks the critical-first modulo-16 order. Because every request is logged, the error is pinned to the exact beat.

// File: rtl/icfc_pkg.sv
package icfc_pkg;
  localparam int ADDR_W     = 32;
  localparam int WORD_W     = 32;
  localparam int LINE_WORDS = 4;
  localparam int WSEL_W     = $clog2(LINE_WORDS);
  localparam int LINE_W     = ADDR_W - WSEL_W - 2;

  typedef enum logic [1:0] {ST_IDLE, ST_COPY, ST_FILL, ST_BYP} fill_st_e;
  typedef logic [LINE_WORDS*WORD_W-1:0] line_data_t;

  // index of last beat for a miss under the given mode
  function automatic logic [WSEL_W-1:0] last_beat(input logic [1:0] mode, input logic a3);
    if (mode == 2'b00 || (mode == 2'b01 && !a3)) return WSEL_W'(LINE_WORDS - 1);
    return '0;
  endfunction
endpackage

// File: rtl/icfc_tag_array.sv
module icfc_tag_array
  import icfc_pkg::*;
#(
  parameter int SETS  = 64,
  parameter int IDX_W = $clog2(SETS),
  parameter int TAG_W = LINE_W - IDX_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              inval_i,
  input  logic [IDX_W-1:0]  rd_idx_i,
  input  logic [TAG_W-1:0]  rd_tag_i,
  input  logic [WSEL_W-1:0] rd_word_i,
  output logic              hit_o,
  output logic [WORD_W-1:0] rd_data_o,
  input  logic              wr_en_i,
  input  logic [IDX_W-1:0]  wr_idx_i,
  input  logic [TAG_W-1:0]  wr_tag_i,
  input  line_data_t        wr_line_i
);
  logic [SETS-1:0]  vld_q;
  logic [TAG_W-1:0] tag_q  [SETS];
  line_data_t       data_q [SETS];

  // no reset: contents survive reset, software invalidates
  always_ff @(posedge clk_i) begin
    if (inval_i)      vld_q <= '0;
    else if (wr_en_i) vld_q[wr_idx_i] <= 1'b1;
    if (wr_en_i) begin
      tag_q[wr_idx_i]  <= wr_tag_i;
      data_q[wr_idx_i] <= wr_line_i;
    end
  end

  assign hit_o     = vld_q[rd_idx_i] && (tag_q[rd_idx_i] == rd_tag_i);
  assign rd_data_o = data_q[rd_idx_i][rd_word_i*WORD_W +: WORD_W];

  // R10
  inval_array_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inval_i |=> !hit_o);
endmodule

// File: rtl/icfc_fill_buf.sv
module icfc_fill_buf
  import icfc_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              inval_i,
  input  logic              start_i,
  input  logic [LINE_W-1:0] start_line_i,
  input  logic              wr_en_i,
  input  logic [WSEL_W-1:0] wr_idx_i,
  input  logic [WORD_W-1:0] wr_data_i,
  input  logic [LINE_W-1:0] look_line_i,
  input  logic [WSEL_W-1:0] look_word_i,
  output logic              hit_o,
  output logic [WORD_W-1:0] rd_word_o,
  output logic              full_o,
  output logic              mru_o,
  output logic [LINE_W-1:0] line_o,
  output line_data_t        line_data_o
);
  logic [LINE_W-1:0]     line_q;
  logic [LINE_WORDS-1:0] vmask_q;
  logic                  mru_q;
  line_data_t            data_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      line_q  <= '0;
      vmask_q <= '0;
      mru_q   <= 1'b0;
    end else if (inval_i) begin
      vmask_q <= '0;
      mru_q   <= 1'b0;
    end else if (start_i) begin
      line_q  <= start_line_i;
      vmask_q <= '0;
      mru_q   <= 1'b1;
    end else if (wr_en_i) begin
      vmask_q[wr_idx_i] <= 1'b1;
    end
  end

  always_ff @(posedge clk_i) begin
    if (wr_en_i) data_q[wr_idx_i*WORD_W +: WORD_W] <= wr_data_i;
  end

  assign hit_o       = (line_q == look_line_i) && vmask_q[look_word_i];
  assign rd_word_o   = data_q[look_word_i*WORD_W +: WORD_W];
  assign full_o      = &vmask_q;
  assign mru_o       = mru_q;
  assign line_o      = line_q;
  assign line_data_o = data_q;

  // R3
  once_per_fill_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |-> !vmask_q[wr_idx_i]);
  // R4
  wrap_order_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i && (vmask_q != '0) |-> vmask_q[wr_idx_i - WSEL_W'(1)]);
  // R10
  inval_buf_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inval_i |=> (vmask_q == '0) && !mru_q);
endmodule

// File: rtl/icfc_fill_fsm.sv
module icfc_fill_fsm
  import icfc_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic [1:0]        mode_i,
  input  logic              inval_i,
  input  logic              req_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              inhibit_i,
  input  logic              ctrl_space_i,
  input  logic              buf_hit_i,
  input  logic              arr_hit_i,
  input  logic              buf_full_i,
  input  logic              buf_mru_i,
  input  logic              mem_ack_i,
  output logic              busy_o,
  output logic              hit_ack_o,
  output logic              mem_ready_o,
  output logic              mem_req_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic              start_o,
  output logic [LINE_W-1:0] start_line_o,
  output logic              wr_en_o,
  output logic [WSEL_W-1:0] wr_idx_o,
  output logic              copy_o
);
  fill_st_e            st_q;
  logic [ADDR_W-3:0]   miss_q;
  logic [WSEL_W-1:0]   cnt_q, last_q, beat_w;
  logic                take, cacheable, miss, byp_go, copy_go, beat_ack;
  logic                unused_addr_lsb;

  assign unused_addr_lsb = ^addr_i[1:0];

  assign cacheable = en_i && !inhibit_i && !ctrl_space_i;
  assign take      = (st_q == ST_IDLE) && req_i && !inval_i;
  assign hit_ack_o = take && cacheable && (buf_hit_i || arr_hit_i);
  assign miss      = take && cacheable && !buf_hit_i && !arr_hit_i;
  assign byp_go    = take && !cacheable;
  assign copy_go   = miss && buf_full_i && buf_mru_i;

  assign beat_w    = miss_q[WSEL_W-1:0] + cnt_q;
  assign beat_ack  = (st_q == ST_FILL) && mem_ack_i;

  assign busy_o       = (st_q != ST_IDLE);
  assign mem_req_o    = (st_q == ST_FILL) || (st_q == ST_BYP);
  assign mem_addr_o   = (st_q == ST_BYP) ? {miss_q, 2'b00}
                                         : {miss_q[ADDR_W-3:WSEL_W], beat_w, 2'b00};
  assign wr_en_o      = beat_ack;
  assign wr_idx_o     = beat_w;
  assign mem_ready_o  = (beat_ack && cnt_q == '0) || ((st_q == ST_BYP) && mem_ack_i);
  assign copy_o       = (st_q == ST_COPY);
  assign start_o      = (miss && !copy_go) || (st_q == ST_COPY);
  assign start_line_o = (st_q == ST_COPY) ? miss_q[ADDR_W-3:WSEL_W] : addr_i[ADDR_W-1:WSEL_W+2];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      miss_q <= '0;
      cnt_q  <= '0;
      last_q <= '0;
    end else begin
      unique case (st_q)
        ST_IDLE: begin
          if (byp_go) begin
            miss_q <= addr_i[ADDR_W-1:2];
            st_q   <= ST_BYP;
          end else if (miss) begin
            miss_q <= addr_i[ADDR_W-1:2];
            cnt_q  <= '0;
            last_q <= last_beat(mode_i, addr_i[3]);
            st_q   <= copy_go ? ST_COPY : ST_FILL;
          end
        end
        ST_COPY: st_q <= ST_FILL;
        ST_FILL: if (mem_ack_i) begin
          if (cnt_q == last_q) st_q <= ST_IDLE;
          else                 cnt_q <= cnt_q + WSEL_W'(1);
        end
        ST_BYP: if (mem_ack_i) st_q <= ST_IDLE;
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  // R9
  copy_then_fill_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_COPY) |=> (st_q == ST_FILL));
  // R5
  addr_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && !mem_ack_i |=> mem_req_o && $stable(mem_addr_o));
  // R7
  bypass_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_BYP) && mem_ack_i |=> !mem_req_o);
endmodule

// File: rtl/icache_fill_ctrl.sv
module icache_fill_ctrl
  import icfc_pkg::*;
#(
  parameter int SETS = 64
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        cache_en_i,
  input  logic [1:0]  fill_mode_i,
  input  logic        inval_all_i,
  input  logic        fetch_req_i,
  input  logic [31:0] fetch_addr_i,
  input  logic        inhibit_i,
  input  logic        ctrl_space_i,
  output logic        fetch_ready_o,
  output logic [31:0] fetch_data_o,
  output logic        mem_req_o,
  output logic [31:0] mem_addr_o,
  input  logic        mem_ack_i,
  input  logic [31:0] mem_data_i
);
  localparam int IDX_W = $clog2(SETS);
  localparam int TAG_W = LINE_W - IDX_W;

  logic              en_q;
  logic [1:0]        mode_q;
  logic [LINE_W-1:0] look_line, buf_line, start_line;
  logic [WSEL_W-1:0] look_word, wr_idx;
  logic              buf_hit, arr_hit, buf_full, buf_mru;
  logic [WORD_W-1:0] buf_word, arr_word;
  line_data_t        buf_data;
  logic              busy, hit_ack, mem_ready, start, wr_en, copy;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q   <= 1'b0;
      mode_q <= 2'b00;
    end else begin
      en_q   <= cache_en_i;
      mode_q <= fill_mode_i;
    end
  end

  assign look_line = fetch_addr_i[ADDR_W-1:WSEL_W+2];
  assign look_word = fetch_addr_i[WSEL_W+1:2];

  icfc_fill_fsm i_fsm (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .en_i         (en_q),
    .mode_i       (mode_q),
    .inval_i      (inval_all_i),
    .req_i        (fetch_req_i),
    .addr_i       (fetch_addr_i),
    .inhibit_i    (inhibit_i),
    .ctrl_space_i (ctrl_space_i),
    .buf_hit_i    (buf_hit),
    .arr_hit_i    (arr_hit),
    .buf_full_i   (buf_full),
    .buf_mru_i    (buf_mru),
    .mem_ack_i    (mem_ack_i),
    .busy_o       (busy),
    .hit_ack_o    (hit_ack),
    .mem_ready_o  (mem_ready),
    .mem_req_o    (mem_req_o),
    .mem_addr_o   (mem_addr_o),
    .start_o      (start),
    .start_line_o (start_line),
    .wr_en_o      (wr_en),
    .wr_idx_o     (wr_idx),
    .copy_o       (copy)
  );

  icfc_fill_buf i_buf (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .inval_i      (inval_all_i),
    .start_i      (start),
    .start_line_i (start_line),
    .wr_en_i      (wr_en),
    .wr_idx_i     (wr_idx),
    .wr_data_i    (mem_data_i),
    .look_line_i  (look_line),
    .look_word_i  (look_word),
    .hit_o        (buf_hit),
    .rd_word_o    (buf_word),
    .full_o       (buf_full),
    .mru_o        (buf_mru),
    .line_o       (buf_line),
    .line_data_o  (buf_data)
  );

  icfc_tag_array #(.SETS(SETS), .IDX_W(IDX_W), .TAG_W(TAG_W)) i_tags (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .inval_i   (inval_all_i),
    .rd_idx_i  (look_line[IDX_W-1:0]),
    .rd_tag_i  (look_line[LINE_W-1:IDX_W]),
    .rd_word_i (look_word),
    .hit_o     (arr_hit),
    .rd_data_o (arr_word),
    .wr_en_i   (copy),
    .wr_idx_i  (buf_line[IDX_W-1:0]),
    .wr_tag_i  (buf_line[LINE_W-1:IDX_W]),
    .wr_line_i (buf_data)
  );

  // buffer is the current copy of its line, so it wins over the array
  assign fetch_ready_o = hit_ack || mem_ready;
  assign fetch_data_o  = mem_ready ? mem_data_i : (buf_hit ? buf_word : arr_word);

  // R5
  fill_stall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy && !mem_ack_i |-> !fetch_ready_o);
  // R2
  disabled_no_hit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_q |-> !hit_ack);
endmodule

// File: tb/test_icache_fill_ctrl.sv
module test_icache_fill_ctrl;
  timeunit 1ns;
  timeprecision 1ps;

  localparam int SETS  = 64;
  localparam int IDX_W = $clog2(SETS);
  localparam int TAG_W = 28 - IDX_W;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        cache_en = 1'b0, inval = 1'b0, req = 1'b0, inh = 1'b0, cs = 1'b0;
  logic [1:0]  mode = 2'b00;
  logic [31:0] addr = '0;
  logic        fetch_ready_o, mem_req_o;
  logic [31:0] fetch_data_o, mem_addr_o;
  logic        mem_ack = 1'b0;
  logic [31:0] mem_data = '0;

  int n_chk = 0, n_fail = 0, txn = 0;
  logic [31:0] mlog [64];

  // bench model
  bit             m_vld [SETS];
  logic [TAG_W-1:0] m_tag [SETS];
  logic [27:0]    b_line;
  logic [3:0]     b_vm;
  bit             b_mru, m_en;
  logic [1:0]     m_mode;

  always #10 clk = ~clk;

  icache_fill_ctrl #(.SETS(SETS)) i_icache_fill_ctrl (
    .clk_i(clk), .rst_ni(rst_ni), .cache_en_i(cache_en), .fill_mode_i(mode),
    .inval_all_i(inval), .fetch_req_i(req), .fetch_addr_i(addr), .inhibit_i(inh),
    .ctrl_space_i(cs), .fetch_ready_o(fetch_ready_o), .fetch_data_o(fetch_data_o),
    .mem_req_o(mem_req_o), .mem_addr_o(mem_addr_o), .mem_ack_i(mem_ack), .mem_data_i(mem_data)
  );

  function automatic logic [31:0] mdata(input logic [31:0] a);
    return ({a[31:2], 2'b00} * 32'h9E37_79B1) ^ 32'h1234_5678;
  endfunction

  always @(negedge clk) begin
    if (mem_req_o && ($urandom_range(0, 2) != 0)) begin
      mem_ack = 1'b1;
      mem_data = mdata(mem_addr_o);
      mlog[txn % 64] = mem_addr_o;
      txn++;
    end else begin
      mem_ack = 1'b0;
      mem_data = $urandom;
    end
  end

  task automatic check(input bit ok, input string r, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", r, act, exp);
    end
  endtask

  task automatic model_access(input logic [31:0] a, input bit i, input bit c, output int nb);
    logic [27:0] ln = a[31:4];
    logic [1:0] w = a[3:2];
    nb = 0;
    if (!m_en || i || c) nb = 1;
    else if (b_line == ln && b_vm[w]) nb = 0;
    else if (m_vld[ln[IDX_W-1:0]] && m_tag[ln[IDX_W-1:0]] == ln[27:IDX_W]) nb = 0;
    else begin
      if (b_vm == 4'hF && b_mru) begin
        m_vld[b_line[IDX_W-1:0]] = 1'b1;
        m_tag[b_line[IDX_W-1:0]] = b_line[27:IDX_W];
      end
      nb = (m_mode == 2'b00 || (m_mode == 2'b01 && !a[3])) ? 4 : 1;
      b_line = ln;
      b_vm = (nb == 4) ? 4'hF : (4'b0001 << w);
      b_mru = 1'b1;
    end
  endtask

  task automatic do_fetch(input logic [31:0] a, input bit i, input bit c,
                          output logic [31:0] d, output int waits, output bit busy_rdy);
    waits = 0; busy_rdy = 0; d = '0;
    @(negedge clk);
    req = 1'b1; addr = a; inh = i; cs = c;
    forever begin
      #5;
      if (fetch_ready_o) begin
        d = fetch_data_o;
        if (mem_req_o && !mem_ack) busy_rdy = 1;
        @(negedge clk);
        req = 1'b0;
        break;
      end
      if (mem_req_o) busy_rdy = busy_rdy | fetch_ready_o;
      waits++;
      if (waits > 100) begin
        check(0, "R5 fetch timeout", waits, 100);
        req = 1'b0;
        break;
      end
      @(negedge clk);
    end
  endtask

  task automatic settle();
    do begin @(negedge clk); #5; end while (mem_req_o);
  endtask

  task automatic acc(input logic [31:0] a, input bit i, input bit c, input string r);
    int nb, t0, w;
    logic [31:0] d, e;
    bit bz;
    model_access(a, i, c, nb);
    t0 = txn;
    do_fetch(a, i, c, d, w, bz);
    check(d == mdata(a), r, d, mdata(a));
    settle();
    check(txn - t0 == nb, r, txn - t0, nb);
    if (nb > 0) check(mlog[t0 % 64] == {a[31:2], 2'b00}, r, mlog[t0 % 64], {a[31:2], 2'b00});
    if (nb == 4)
      for (int k = 1; k < 4; k++) begin
        e = {a[31:4], 2'(a[3:2] + 2'(k)), 2'b00};
        check(mlog[(t0 + k) % 64] == e, "R4 wrap order", mlog[(t0 + k) % 64], e);
      end
  endtask

  task automatic set_ctl(input bit e, input logic [1:0] m);
    @(negedge clk); cache_en = e; mode = m;
    @(negedge clk); m_en = e; m_mode = m;
  endtask

  task automatic do_inval();
    @(negedge clk); inval = 1'b1;
    @(negedge clk); inval = 1'b0;
    for (int s = 0; s < SETS; s++) m_vld[s] = 1'b0;
    b_vm = '0; b_mru = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk); rst_ni = 1'b0; cache_en = 1'b0; req = 1'b1; addr = 32'h40;
    #5;
    // R1
    check(!fetch_ready_o, "R1 ready in reset", fetch_ready_o, 0);
    check(!mem_req_o, "R1 mem_req in reset", mem_req_o, 0);
    @(negedge clk); req = 1'b0;
    @(negedge clk); rst_ni = 1'b1;
    m_en = 1'b0; b_vm = '0; b_mru = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++; n_chk++;
    $display("FAIL R5 watchdog act=running exp=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic [31:0] d, a;
    int w, t0, nb;
    bit bz;
    void'($urandom(32'd2718));
    for (int s = 0; s < SETS; s++) m_vld[s] = 1'b0;
    b_line = '0; b_vm = '0; b_mru = 1'b0; m_en = 1'b0; m_mode = 2'b00;

    do_reset();
    // R1 R2: disabled after reset -> single transfer
    acc(32'h0000_0104, 0, 0, "R1 bypass after reset");
    acc(32'h0000_0108, 0, 0, "R2 disabled bypass");

    do_inval();
    set_ctl(1, 2'b00);
    // R3 R4: all four starting offsets
    acc(32'h0000_1000, 0, 0, "R3 fill off0");
    acc(32'h0000_2014, 0, 0, "R3 fill off4");
    acc(32'h0000_3028, 0, 0, "R3 fill off8");
    acc(32'h0000_403C, 0, 0, "R3 fill offC");
    // R6 buffer hits
    acc(32'h0000_4030, 0, 0, "R6 buffer hit");
    acc(32'h0000_4034, 0, 0, "R6 buffer hit");
    // R9 copied lines hit in array
    acc(32'h0000_3020, 0, 0, "R9 array hit");
    acc(32'h0000_1008, 0, 0, "R9 array hit");

    // R5 critical first then stall
    model_access(32'h0000_5008, 0, 0, nb);
    t0 = txn;
    do_fetch(32'h0000_5008, 0, 0, d, w, bz);
    check(d == mdata(32'h5008), "R5 critical data", d, mdata(32'h5008));
    #5;
    check(mem_req_o == 1'b1, "R5 fill continues after critical", mem_req_o, 1);
    model_access(32'h0000_500C, 0, 0, nb);
    do_fetch(32'h0000_500C, 0, 0, d, w, bz);
    check(!bz, "R5 no ready while filling", bz, 0);
    check(w > 0, "R5 stalled during fill", w, 1);
    check(d == mdata(32'h500C), "R5 data after stall", d, mdata(32'h500C));
    settle();
    check(txn - t0 == 4, "R5 beats", txn - t0, 4);

    // R7 inhibited and control space leave caches alone
    acc(32'h0000_2018, 1, 0, "R7 inhibited");
    acc(32'h0000_2018, 0, 1, "R7 control space");
    acc(32'h0000_5004, 1, 0, "R7 inhibited on buffer line");
    acc(32'h0000_2018, 0, 0, "R7 array intact");
    acc(32'h0000_5000, 0, 0, "R7 buffer intact");

    // R8 fill modes
    set_ctl(1, 2'b01);
    acc(32'h0000_6008, 0, 0, "R8 mode01 a3=1");
    acc(32'h0000_6008, 0, 0, "R8 partial hit");
    acc(32'h0000_600C, 0, 0, "R8 partial miss");
    acc(32'h0000_6004, 0, 0, "R8 mode01 a3=0");
    set_ctl(1, 2'b10);
    acc(32'h0000_7004, 0, 0, "R8 mode10");
    acc(32'h0000_7004, 0, 0, "R8 partial hit");
    acc(32'h0000_7000, 0, 0, "R8 partial miss");
    set_ctl(1, 2'b11);
    acc(32'h0000_780C, 0, 0, "R8 mode11");

    // R10 invalidate
    set_ctl(1, 2'b00);
    do_inval();
    acc(32'h0000_1000, 0, 0, "R10 miss after inval");
    acc(32'h0000_3020, 0, 0, "R10 miss after inval");

    // R11 array survives reset
    acc(32'h0000_8000, 0, 0, "R11 fill");
    acc(32'h0000_9000, 0, 0, "R11 fill and copy");
    do_reset();
    set_ctl(1, 2'b00);
    acc(32'h0000_8004, 0, 0, "R11 hit after reset");
    acc(32'h0000_9004, 0, 0, "R11 buffer cleared by reset");

    // constrained random
    for (int n = 0; n < 400; n++) begin
      if (n % 50 == 0) set_ctl(($urandom_range(0, 4) != 0), 2'($urandom_range(0, 3)));
      if (n % 97 == 96) do_inval();
      a = ($urandom_range(0, 15) << 10) | ($urandom_range(0, 3) << 4) | ($urandom_range(0, 3) << 2);
      acc(a, ($urandom_range(0, 7) == 0), ($urandom_range(0, 15) == 0), "R3 R6 R9 random");
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule